// File: doc/BRIEF.md
# Processor Local Bus Cycle Monitor

This block sits beside a 32-bit processor's local bus and reports every bus cycle it sees. The bus is timed by a fast clock that runs at twice the processor's own rate. The monitor divides that clock by two to rebuild the processor's internal phase. It accepts the three status lines only on a fast-clock edge where the active-low address strobe is low and the rebuilt phase is high. Each accepted cycle becomes a one-clock report pulse, a three-bit type code and a flag for a locked memory access.

The monitor also serves a second bus master. When that master asks for the bus, the monitor grants it through an acknowledge line. The grant is never given while the processor holds its lock output for an indivisible read-modify-write sequence. While the grant is high, no cycles are reported. A status code that no valid cycle may carry sets a sticky error flag.

Top module: `bus_cycle_monitor`

## Requirements
- R1: While `rst` is high (synchronous, active high), `cycleValid`, `cycleLocked`, `holdAck` and `protoErr` are 0, `cycleType` is 000 and the internal phase is low.
- R2: The internal phase toggles on every `fastClk` rising edge. It is low during reset, so the phase-high edges are the 2nd, 4th, 6th, … edges after reset is released.
- R3: Status is sampled only on a phase-high edge with `strobeN` low. A low strobe on any other edge has no effect on the outputs.
- R4: A sampled cycle raises `cycleValid` for exactly one `fastClk` cycle, in the cycle that follows the sampling edge.
- R5: `cycleType` = {`stMem`, `stData`, `stWrite`}, with `stWrite` in bit 0. The codes are 000 interrupt acknowledge, 001 unused, 010 I/O read, 011 I/O write, 100 instruction fetch, 101 halt/shutdown, 110 memory read, 111 memory write.
- R6: `cycleType` keeps its value until the next reported cycle.
- R7: `cycleLocked` takes the value of `busLock` at the sampling edge when the type is 110 or 111, and is 0 for every other type. It is held along with `cycleType`.
- R8: Status values present while `strobeN` is high produce no pulse, no type change and no error.
- R9: Code 001 sampled under a valid strobe produces no pulse and leaves the type unchanged. It sets `protoErr`, which stays 1 until reset.
- R10: `holdAck` rises on the first phase-high edge where `holdReq` is 1, `busLock` is 0 and `strobeN` is 1.
- R11: While `busLock` is 1, `holdAck` is not granted.
- R12: `holdAck` falls on the first phase-high edge where `holdReq` is 0, which is at most two `fastClk` cycles after the request drops.
- R13: While `holdAck` is high, no cycle is sampled and `cycleValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Double-rate bus clock |
| rst | input | 1 | Synchronous active-high reset |
| strobeN | input | 1 | Active-low address strobe |
| stMem | input | 1 | Status: 1 = memory, 0 = I/O |
| stData | input | 1 | Status: 1 = data, 0 = control |
| stWrite | input | 1 | Status: 1 = write, 0 = read |
| busLock | input | 1 | Processor lock output, active high |
| holdReq | input | 1 | Bus request from the alternate master |
| cycleValid | output | 1 | One-cycle pulse per reported bus cycle |
| cycleType | output | 3 | Code of the last reported cycle |
| cycleLocked | output | 1 | Last reported memory cycle was locked |
| holdAck | output | 1 | Bus granted to the alternate master |
| protoErr | output | 1 | Sticky flag for the unused status code |

## Verification
The report pulse, type code, lock flag and error flag are all registered on the sampling edge, so each one is due one `fastClk` cycle after that edge. The hold acknowledge moves only on phase-high edges, so it is due within two cycles of a change in the request or the lock. The bench drives its inputs on falling edges and compares every output on the next falling edge. It compares against a reference model that advances on the same rising edge as the design. Directed checks cover the lock/hold interplay and the unused code, and they sample after a fixed number of cycles counted from the requirements.

// File: rtl/bcm_pkg.sv
`timescale 1ns/1ps
package bcm_pkg;
  parameter int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    CYC_INTA  = 3'b000,
    CYC_RSVD  = 3'b001,
    CYC_IORD  = 3'b010,
    CYC_IOWR  = 3'b011,
    CYC_FETCH = 3'b100,
    CYC_HALT  = 3'b101,
    CYC_MEMRD = 3'b110,
    CYC_MEMWR = 3'b111
  } cycle_e;

  typedef struct packed {
    logic captureStb;
    logic errStb;
  } ctrl_t;
endpackage

// File: rtl/bcm_ctrl.sv
`timescale 1ns/1ps
module bcm_ctrl
  import bcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strobeN,
  input  logic [TYPE_W-1:0] code,
  input  logic              busLock,
  input  logic              holdReq,
  output ctrl_t             strobes,
  output logic              holdAck
);
  logic phaseHi;
  logic holdAckQ;
  logic qualify;

  // Divide-by-two phase recovery
  always_ff @(posedge clk) begin
    if (rst) phaseHi <= 1'b0;
    else     phaseHi <= ~phaseHi;
  end

  assign qualify            = phaseHi & ~strobeN & ~holdAckQ;
  assign strobes.captureStb = qualify & (code != CYC_RSVD);
  assign strobes.errStb     = qualify & (code == CYC_RSVD);

  // Hold handshake, evaluated on phase-high edges only
  always_ff @(posedge clk) begin
    if (rst) begin
      holdAckQ <= 1'b0;
    end else if (phaseHi) begin
      if (holdAckQ && !holdReq)
        holdAckQ <= 1'b0;
      else if (!holdAckQ && holdReq && !busLock && strobeN)
        holdAckQ <= 1'b1;
    end
  end

  assign holdAck = holdAckQ;

  AST_GRANT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(holdAckQ) |-> $past(!busLock)); // R11
  AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(holdAckQ) |-> $past(!holdReq)); // R12
  AST_ACK_ON_PHASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(holdAckQ) || $fell(holdAckQ)) |-> $past(phaseHi)); // R10
  AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    phaseHi |=> !phaseHi); // R2
endmodule

// File: rtl/bcm_datapath.sv
`timescale 1ns/1ps
module bcm_datapath
  import bcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             strobes,
  input  logic [TYPE_W-1:0] code,
  input  logic              busLock,
  output logic              cycleValid,
  output logic [TYPE_W-1:0] cycleType,
  output logic              cycleLocked,
  output logic              protoErr
);
  logic isMem;
  assign isMem = (code == CYC_MEMRD) || (code == CYC_MEMWR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleValid  <= 1'b0;
      cycleType   <= '0;
      cycleLocked <= 1'b0;
      protoErr    <= 1'b0;
    end else begin
      cycleValid <= strobes.captureStb;
      if (strobes.captureStb) begin
        cycleType   <= code;
        cycleLocked <= busLock & isMem;
      end
      if (strobes.errStb) protoErr <= 1'b1;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cycleValid |=> !cycleValid); // R4
  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (rst)
    !cycleValid |-> $stable(cycleType)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> protoErr); // R9
  AST_NO_RSVD_REPORT: assert property (@(posedge clk) disable iff (rst)
    cycleValid |-> (cycleType != CYC_RSVD)); // R9
  AST_LOCK_MEM_ONLY: assert property (@(posedge clk) disable iff (rst)
    cycleLocked |-> (cycleType[2:1] == 2'b11)); // R7
endmodule

// File: rtl/bus_cycle_monitor.sv
`timescale 1ns/1ps
module bus_cycle_monitor
  import bcm_pkg::*;
(
  input  logic              fastClk,
  input  logic              rst,
  input  logic              strobeN,
  input  logic              stMem,
  input  logic              stData,
  input  logic              stWrite,
  input  logic              busLock,
  input  logic              holdReq,
  output logic              cycleValid,
  output logic [TYPE_W-1:0] cycleType,
  output logic              cycleLocked,
  output logic              holdAck,
  output logic              protoErr
);
  ctrl_t             strobes;
  logic [TYPE_W-1:0] code;

  assign code = {stMem, stData, stWrite};

  bcm_ctrl ctrl_i (
    .clk(fastClk), .rst(rst), .strobeN(strobeN), .code(code),
    .busLock(busLock), .holdReq(holdReq), .strobes(strobes), .holdAck(holdAck)
  );

  bcm_datapath dp_i (
    .clk(fastClk), .rst(rst), .strobes(strobes), .code(code), .busLock(busLock),
    .cycleValid(cycleValid), .cycleType(cycleType),
    .cycleLocked(cycleLocked), .protoErr(protoErr)
  );

  AST_NO_CYCLE_IN_HOLD: assert property (@(posedge fastClk) disable iff (rst)
    cycleValid |-> !holdAck); // R13
endmodule

// File: tb/bus_cycle_monitor_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_monitor_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic strobeN = 1'b1, stMem = 1'b0, stData = 1'b0, stWrite = 1'b0;
  logic busLock = 1'b0, holdReq = 1'b0;
  logic cycleValid, cycleLocked, holdAck, protoErr;
  logic [2:0] cycleType;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // Reference model state
  logic mPhase = 1'b0, mValid = 1'b0, mLock = 1'b0, mAck = 1'b0, mErr = 1'b0;
  logic [2:0] mType = 3'b000;

  always #5 clk = ~clk;

  bus_cycle_monitor dut_i (
    .fastClk(clk), .rst(rst), .strobeN(strobeN), .stMem(stMem), .stData(stData),
    .stWrite(stWrite), .busLock(busLock), .holdReq(holdReq),
    .cycleValid(cycleValid), .cycleType(cycleType), .cycleLocked(cycleLocked),
    .holdAck(holdAck), .protoErr(protoErr)
  );

  function automatic logic isMemCode(input logic [2:0] c);
    return c[2] & c[1];
  endfunction

  function automatic logic grantNow(input logic ack, input logic req,
                                    input logic lk, input logic sN);
    return !ack && req && !lk && sN;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase <= 1'b0; mValid <= 1'b0; mType <= 3'b000;
      mLock <= 1'b0; mAck <= 1'b0; mErr <= 1'b0;
    end else begin
      mPhase <= ~mPhase;
      mValid <= 1'b0;
      if (mPhase) begin
        if (!mAck && !strobeN) begin
          if ({stMem, stData, stWrite} == 3'b001) mErr <= 1'b1;
          else begin
            mValid <= 1'b1;
            mType  <= {stMem, stData, stWrite};
            mLock  <= busLock & isMemCode({stMem, stData, stWrite});
          end
        end
        if (mAck && !holdReq) mAck <= 1'b0;
        else if (grantNow(mAck, holdReq, busLock, strobeN)) mAck <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R2 R3 R4 R8 R13", "cycleValid", {2'b0, cycleValid}, {2'b0, mValid});
    check("R5 R6", "cycleType", cycleType, mType);
    check("R7", "cycleLocked", {2'b0, cycleLocked}, {2'b0, mLock});
    check("R9", "protoErr", {2'b0, protoErr}, {2'b0, mErr});
    check("R10 R11 R12", "holdAck", {2'b0, holdAck}, {2'b0, mAck});
  endtask

  task automatic drive(input logic s, input logic [2:0] c, input logic l, input logic h);
    strobeN = s; {stMem, stData, stWrite} = c; busLock = l; holdReq = h;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    drive(1'b0, 3'b110, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    // R1: reset state, with active inputs applied
    check("R1", "cycleValid", {2'b0, cycleValid}, 3'd0);
    check("R1", "cycleType", cycleType, 3'd0);
    check("R1", "cycleLocked", {2'b0, cycleLocked}, 3'd0);
    check("R1", "holdAck", {2'b0, holdAck}, 3'd0);
    check("R1", "protoErr", {2'b0, protoErr}, 3'd0);
    drive(1'b1, 3'b000, 1'b0, 1'b0);
    rst = 1'b0;

    // R2 R3 R5: strobe pulses of one cycle at both edge parities
    for (int k = 0; k < 12; k++) begin
      if (k % 3 == 0) drive(1'b0, (k % 2 == 0) ? 3'b110 : 3'b011, k[2], 1'b0);
      else            drive(1'b1, 3'b101, 1'b0, 1'b0);
      step(1);
    end
    // R2 R3: a single low strobe on the 1st edge is ignored, one on the 2nd is reported
    rst = 1'b1; step(2); rst = 1'b0;
    drive(1'b0, 3'b010, 1'b0, 1'b0); @(negedge clk);
    check("R3", "cycleValid odd edge", {2'b0, cycleValid}, 3'd0);
    drive(1'b0, 3'b100, 1'b0, 1'b0); @(negedge clk);
    check("R2", "cycleValid even edge", {2'b0, cycleValid}, 3'd1);
    check("R5", "cycleType fetch", cycleType, 3'b100);
    drive(1'b1, 3'b000, 1'b0, 1'b0); step(2);

    // R11: lock blocks grant
    drive(1'b1, 3'b000, 1'b1, 1'b1); step(8);
    check("R11", "holdAck under lock", {2'b0, holdAck}, 3'd0);
    drive(1'b1, 3'b000, 1'b0, 1'b1); step(2);
    check("R10", "holdAck after unlock", {2'b0, holdAck}, 3'd1);
    // R13: strobe during hold is not reported
    drive(1'b0, 3'b111, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1);
      check("R13", "cycleValid in hold", {2'b0, cycleValid}, 3'd0);
    end
    drive(1'b1, 3'b000, 1'b0, 1'b0); step(2);
    check("R12", "holdAck after drop", {2'b0, holdAck}, 3'd0);

    // R8: unused code under high strobe ignored; R9: sticky error
    drive(1'b1, 3'b001, 1'b0, 1'b0); step(4);
    check("R8", "protoErr strobe high", {2'b0, protoErr}, 3'd0);
    drive(1'b0, 3'b001, 1'b0, 1'b0); step(2);
    check("R9", "protoErr set", {2'b0, protoErr}, 3'd1);
    drive(1'b1, 3'b110, 1'b0, 1'b0); step(3);
    check("R9", "protoErr held", {2'b0, protoErr}, 3'd1);

    // Constrained random section
    for (int i = 0; i < 3000; i++) begin
      logic s, l, h;
      s = ($urandom % 4) != 0;
      l = (($urandom % 8) == 0) ? ~busLock : busLock;
      h = (($urandom % 16) == 0) ? ~holdReq : holdReq;
      drive(s, 3'($urandom % 8), l, h);
      step(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule